// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a bus-programmed watchdog that gives software two chances before a system reset is requested. A down-counter starts from a programmable reload value. When it first runs out, the block raises an interrupt and starts counting again from the reload value. If the counter runs out a second time while that interrupt is still unacknowledged and reset generation is enabled, the block asserts a reset request. The request stays asserted until the block itself is reset. Software keeps the system alive by writing the kick register. A kick clears the pending interrupt and restarts the count.

A guard register protects every other register. Writing the 32-bit key `0x1ACCE551` to it opens the registers for writing, and writing any other value closes them again. The register interface is a simple synchronous bus. A write takes effect on the clock edge where the write enable is high. A read returns its data on `bus_rdata` one edge after the read enable is sampled.

The escalation is a three-state machine. **QUIET** means no interrupt is pending. **PENDING** means the raw interrupt flag is set. **TRIPPED** means the reset request is asserted, and this state is absorbing. The transitions are:
- QUIET→PENDING on an expiry.
- PENDING→QUIET on a kick.
- PENDING→TRIPPED on an expiry while reset generation is enabled.
- PENDING→PENDING on an expiry while reset generation is disabled. The counter simply reloads.

Top module: `wdog_dual_stage`

## Requirements
- R1: After reset the registers are unlocked and the guard reads 0. Control reads 0, reload and count read all ones of `CNT_W` bits, the raw status reads 0, and `wd_irq` and `wd_reset_req` are both 0.
- R2: While control bit 0 (run) is 1 and no load happens, the count decreases by exactly 1 on every clock edge where it is nonzero.
- R3: When the counter is at 0 on an enabled edge (an expiry), the count becomes the reload value and the raw interrupt flag is set. For reload value L, the interrupt appears L+1 edges after a kick.
- R4: An expiry while the flag is pending and control bit 1 (reset enable) is 1 asserts `wd_reset_req`. This happens 2·(L+1) edges after a kick, and the request stays asserted until `rst_n` is applied.
- R5: An expiry while the flag is pending and reset enable is 0 does not assert `wd_reset_req`. The counter reloads and the flag stays set.
- R6: The raw status register (offset 0x010) reports the flag in bit 0 regardless of control. The masked status register (0x014) and `wd_irq` both equal the flag ANDed with control bit 0.
- R7: A write of `0x1ACCE551` to the guard register (0xC00) unlocks the block, and a write of any other value locks it. A read of the guard returns 1 when locked and 0 when unlocked.
- R8: While the block is locked, writes to the reload (0x000), control (0x008) and kick (0x00C) registers have no effect.
- R9: Any write to the kick register (0x00C) clears the raw flag and loads the count from the reload register.
- R10: A write to the reload register loads the count with the written value on the same edge.
- R11: While control bit 0 is 0, the count holds its value.
- R12: In TRIPPED the count is frozen, and kicks, reload writes and control writes do not release `wd_reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid one edge after `bus_rd` |
| wd_irq | output | 1 | Interrupt, raw flag gated by run |
| wd_reset_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with `CNT_W` = 8. At this width the reset-time reload of 255 is quick to reach, and a sweep over every reload value from 1 to 12 stays short. For each value in the sweep, the bench measures the edge count from a kick to the interrupt and from a kick to the reset request, and compares them with L+1 and 2·(L+1) worked out in the bench. Further sequences cover the following:
- back-to-back count reads that must fall by one per edge;
- lock and unlock using both a near-miss key and the true key;
- the difference between masked and raw status;
- the frozen behaviour after a trip.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] A_RELOAD = 12'h000;
    localparam logic [BUS_AW-1:0] A_COUNT  = 12'h004;
    localparam logic [BUS_AW-1:0] A_CTRL   = 12'h008;
    localparam logic [BUS_AW-1:0] A_KICK   = 12'h00C;
    localparam logic [BUS_AW-1:0] A_RAW    = 12'h010;
    localparam logic [BUS_AW-1:0] A_MASKED = 12'h014;
    localparam logic [BUS_AW-1:0] A_GUARD  = 12'hC00;

    localparam logic [BUS_DW-1:0] GUARD_KEY = 32'h1ACC_E551;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_PENDING = 2'd1,
        ST_TRIPPED = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              raw_flag,
    output logic [BUS_DW-1:0] rdata,
    output logic              ctrl_run,
    output logic              ctrl_rst_en,
    output logic [CNT_W-1:0]  reload_val,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_req,
    output logic              kick_req
);
    localparam logic [CNT_W-1:0] CNT_ONES = '1;

    logic             locked_q;
    logic [1:0]       ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             wr_ok;

    always_comb begin
        wr_ok       = wr_en && !locked_q;
        kick_req    = wr_ok && (addr == A_KICK);
        load_req    = wr_ok && ((addr == A_KICK) || (addr == A_RELOAD));
        load_val    = (addr == A_RELOAD) ? wdata[CNT_W-1:0] : reload_q;
        ctrl_run    = ctrl_q[0];
        ctrl_rst_en = ctrl_q[1];
        reload_val  = reload_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            ctrl_q   <= 2'b00;
            reload_q <= CNT_ONES;
        end else begin
            if (wr_en && (addr == A_GUARD))
                locked_q <= (wdata != GUARD_KEY);
            if (wr_ok && (addr == A_CTRL))
                ctrl_q <= wdata[1:0];
            if (wr_ok && (addr == A_RELOAD))
                reload_q <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (addr)
                A_RELOAD: rdata <= 32'(reload_q);
                A_COUNT:  rdata <= 32'(cnt_val);
                A_CTRL:   rdata <= 32'(ctrl_q);
                A_RAW:    rdata <= 32'(raw_flag);
                A_MASKED: rdata <= 32'(raw_flag & ctrl_q[0]);
                A_GUARD:  rdata <= 32'(locked_q);
                default:  rdata <= '0;
            endcase
        end
    end

    // R8: a locked block keeps control and reload unless the guard is written
    p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !(wr_en && addr == A_GUARD)) |=> ($stable(ctrl_q) && $stable(reload_q)));

    // R7: the true key always opens the block
    p_key_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_GUARD && wdata == GUARD_KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_ONES = '1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt    = cnt_q;
        expire = run && !load && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CNT_ONES;
        else if (load)
            cnt_q <= load_val;
        else if (expire)
            cnt_q <= reload_val;
        else if (run)
            cnt_q <= cnt_q - 1'b1;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    p_expire_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(reload_val)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      expire,
    input  logic      kick,
    input  logic      rst_en,
    output wd_state_e state,
    output logic      raw_flag,
    output logic      reset_req
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (expire) state_d = ST_PENDING;
            ST_PENDING: begin
                if (kick)
                    state_d = ST_QUIET;
                else if (expire && rst_en)
                    state_d = ST_TRIPPED;
            end
            ST_TRIPPED: state_d = ST_TRIPPED;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        state     = state_q;
        raw_flag  = (state_q != ST_QUIET);
        reset_req = (state_q == ST_TRIPPED);
    end

    p_first_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIET && expire) |=> (state_q == ST_PENDING));

    p_kick_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING && kick) |=> (state_q == ST_QUIET));

    p_trip_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIPPED) |=> (state_q == ST_TRIPPED));

    p_no_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING && expire && !rst_en) |=> (state_q == ST_PENDING));
endmodule

// File: rtl/wdog_dual_stage.sv
module wdog_dual_stage
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        wd_irq,
    output logic        wd_reset_req
);
    logic             ctrl_run, ctrl_rst_en, load_req, kick_req;
    logic [CNT_W-1:0] reload_val, load_val, cnt;
    logic             expire, raw_flag, reset_req, tripped;
    wd_state_e        state;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .cnt_val(cnt), .raw_flag(raw_flag),
        .rdata(bus_rdata), .ctrl_run(ctrl_run), .ctrl_rst_en(ctrl_rst_en),
        .reload_val(reload_val), .load_val(load_val),
        .load_req(load_req), .kick_req(kick_req)
    );

    always_comb tripped = (state == ST_TRIPPED);

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_run && !tripped), .load(load_req && !tripped),
        .load_val(load_val), .reload_val(reload_val),
        .cnt(cnt), .expire(expire)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .kick(kick_req),
        .rst_en(ctrl_rst_en), .state(state), .raw_flag(raw_flag),
        .reset_req(reset_req)
    );

    always_comb begin
        wd_irq       = raw_flag && ctrl_run;
        wd_reset_req = reset_req;
    end

    // R4: a reset request rises only from a pending flag with reset enabled
    p_trip_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset_req) |-> ($past(raw_flag) && $past(ctrl_rst_en)));

    // R12: once tripped the count is frozen
    p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && $past(tripped)) |-> $stable(cnt));

    // R6: the interrupt pin never shows without run
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> (ctrl_run && raw_flag));
endmodule

// File: tb/wdog_dual_stage_test.sv
module wdog_dual_stage_test;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        wd_irq, wd_reset_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_dual_stage #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .wd_irq(wd_irq), .wd_reset_req(wd_reset_req)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        int n;
        do_reset();

        // R1 reset state
        check("R1 irq", wd_irq, 0);
        check("R1 rst", wd_reset_req, 0);
        rd(12'hC00, v); check("R1 guard", v, 0);
        rd(12'h008, v); check("R1 ctrl", v, 0);
        rd(12'h000, v); check("R1 reload", v, 255);
        rd(12'h004, v); check("R1 count", v, 255);
        rd(12'h010, v); check("R1 raw", v, 0);

        // R10 reload write loads count; R2 stepping
        wr(12'h000, 50);
        rd(12'h004, v); check("R10 count after reload write", v, 50);
        wr(12'h008, 1);
        for (int i = 0; i < 12; i++) begin
            rd(12'h004, v); check("R2 count step", v, 50 - i);
        end
        wr(12'h000, 200);
        rd(12'h004, v); check("R10 reload while running", v, 200);

        // R11 stop holds count
        wr(12'h008, 0);
        rd(12'h004, v0);
        for (int i = 0; i < 5; i++) begin
            rd(12'h004, v); check("R11 hold", v, v0);
        end

        // R5 / R6 / R7 / R8 / R9 sequence
        wr(12'h000, 3);
        wr(12'h008, 1);
        repeat (20) @(posedge clk);
        #1;
        check("R5 no reset without enable", wd_reset_req, 0);
        check("R6 irq pin", wd_irq, 1);
        rd(12'h010, v); check("R5 raw stays set", v, 1);
        rd(12'h014, v); check("R6 masked", v, 1);
        wr(12'hC00, 32'h1ACCE550);
        rd(12'hC00, v); check("R7 near key locks", v, 1);
        wr(12'h00C, 0);
        rd(12'h010, v); check("R8 locked kick ignored", v, 1);
        wr(12'h008, 0);
        rd(12'h008, v); check("R8 locked ctrl ignored", v, 1);
        wr(12'h000, 9);
        rd(12'h000, v); check("R8 locked reload ignored", v, 3);
        wr(12'hC00, 32'h1ACCE551);
        rd(12'hC00, v); check("R7 key unlocks", v, 0);
        wr(12'h008, 0);
        check("R6 irq gated", wd_irq, 0);
        rd(12'h010, v); check("R6 raw ungated", v, 1);
        rd(12'h014, v); check("R6 masked gated", v, 0);
        wr(12'h00C, 32'h0);
        rd(12'h010, v); check("R9 kick clears", v, 0);
        rd(12'h004, v); check("R9 kick reloads", v, 3);
        wr(12'hC00, 1);
        rd(12'hC00, v); check("R7 one locks", v, 1);

        // R3 / R4 timing sweep
        for (int L = 1; L <= 12; L++) begin
            do_reset();
            wr(12'h000, L);
            wr(12'h008, 3);
            wr(12'h00C, 0);
            n = 0;
            while (!wd_irq && n < 1000) begin
                @(posedge clk); #1; n++;
            end
            check("R3 edges to irq", n, L + 1);
            while (!wd_reset_req && n < 1000) begin
                @(posedge clk); #1; n++;
            end
            check("R4 edges to reset", n, 2 * (L + 1));
        end

        // R12 frozen after trip
        rd(12'h004, v0);
        wr(12'h00C, 0);
        wr(12'h000, 7);
        wr(12'h008, 0);
        repeat (5) @(posedge clk);
        #1;
        check("R12 reset sticky", wd_reset_req, 1);
        rd(12'h004, v); check("R12 count frozen", v, v0);
        do_reset();
        check("R4 released by block reset", wd_reset_req, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule